// File: doc/BRIEF.md
# Selectable Capture Trigger Generator

This block watches a set of receiver and RF front-end status signals and turns exactly one of them, picked by a 4-bit condition code, into a single-cycle trigger pulse for a sample-capture buffer. The candidate events fall into three groups:

- **Decoder result pulses:** the frame-check result, the header-field check result and the two preamble detections. Some of these are qualified by pass/fail or by packet kind.
- **Threshold crossings:** RSSI or AGC gain moving across a configurable threshold.
- **Lock transitions:** changes in the AGC lock bit.

Crossings and transitions are found by comparing the present sample with a registered copy of the previous one. Each crossing therefore gives one pulse, however long the level stays on the new side.

The condition code and both thresholds are plain configuration inputs. They are used directly by the logic in the same cycle as the event. Changing them never clears the stored history. The trigger is registered, so it appears one clock after the qualifying input cycle.

Top module: `cap_trigger_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `trig` is 0.
- R2: With code 0, 1 or 2, `trig` is 1 one cycle after `fcs_done` is high. Code 0 fires for any result, code 1 only when `fcs_ok`=1, and code 2 only when `fcs_ok`=0.
- R3: With code 3, 4 or 5, `trig` is 1 one cycle after `hdr_done` is high. Code 3 fires for any result, code 4 only when `hdr_ok`=1, and code 5 only when `hdr_ok`=0.
- R4: Code 6 fires one cycle after `hdr_done` with `hdr_ht`=1, and code 7 one cycle after `hdr_done` with `hdr_ht`=0, whatever `hdr_ok` is.
- R5: Code 8 fires one cycle after `lpre_det`, and code 9 one cycle after `spre_det`.
- R6: Code 10 fires one cycle after a cycle in which `rssi` > `rssi_thr` while the previous cycle's `rssi` was not above it. Code 11 fires one cycle after a cycle in which `rssi` < `rssi_thr` while the previous cycle's `rssi` was not below it. Both comparisons are unsigned, strict, and use the current threshold.
- R7: Code 12 fires one cycle after `agc_lock` goes 1→0 between consecutive cycles, and code 13 one cycle after it goes 0→1.
- R8: Codes 14 and 15 behave like codes 10 and 11, applied to `gain` against `gain_thr`.
- R9: Every `trig` pulse corresponds to exactly one qualifying input cycle. An isolated event gives a one-cycle pulse.
- R10: In the first cycle after reset release, codes 10 to 15 do not fire, because the history is only loaded in that cycle.
- R11: With a code below 10, `trig` stays 0 when the selected decoder pulse is absent, even if other events or crossings occur.
- R12: Changing `rssi_thr`, `gain_thr` or `cond_sel` while the levels stay steady produces no trigger, and the history survives such changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cond_sel | input | 4 | Trigger condition code 0..15 |
| rssi_thr | input | 11 | RSSI threshold |
| gain_thr | input | 7 | Gain threshold |
| fcs_done | input | 1 | Frame-check result pulse |
| fcs_ok | input | 1 | Frame-check passed, valid with `fcs_done` |
| hdr_done | input | 1 | Header-field check result pulse |
| hdr_ok | input | 1 | Header-field check passed, valid with `hdr_done` |
| hdr_ht | input | 1 | Packet is HT, valid with `hdr_done` |
| lpre_det | input | 1 | Long-preamble detection pulse |
| spre_det | input | 1 | Short-preamble detection pulse |
| rssi | input | 11 | RSSI level, half-dB units |
| gain | input | 7 | AGC gain value |
| agc_lock | input | 1 | AGC lock status |
| trig | output | 1 | Registered capture trigger pulse |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the qualifier flags are meaningful only in a cycle where their result pulse is high. The level checks additionally assume that one cycle of history has been gathered since reset; the checker tracks this with its own flag.

The bench drives all inputs just after the falling edge. It keeps RSSI and gain in a narrow band around small thresholds, so that crossings, equal-to-threshold samples and steady stretches all occur often. It also changes thresholds only at points where its own reference model tracks the same history that the requirements describe.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int RSSI_W = 11;
  localparam int GAIN_W = 7;
  localparam int SEL_W  = 4;
  localparam int N_COND = 1 << SEL_W;
  localparam int N_DEC  = 10;

  typedef enum logic [SEL_W-1:0] {
    C_FRM_ANY   = 4'd0,
    C_FRM_PASS  = 4'd1,
    C_FRM_FAIL  = 4'd2,
    C_HDR_ANY   = 4'd3,
    C_HDR_PASS  = 4'd4,
    C_HDR_FAIL  = 4'd5,
    C_HDR_HT    = 4'd6,
    C_HDR_LEG   = 4'd7,
    C_PRE_LONG  = 4'd8,
    C_PRE_SHORT = 4'd9,
    C_RSSI_UP   = 4'd10,
    C_RSSI_DN   = 4'd11,
    C_LOCK_LOST = 4'd12,
    C_LOCK_GOT  = 4'd13,
    C_GAIN_UP   = 4'd14,
    C_GAIN_DN   = 4'd15
  } cond_e;
endpackage

// File: rtl/trig_evt_decode.sv
module trig_evt_decode
  import trig_pkg::*;
(
  input  logic             fcs_done,
  input  logic             fcs_ok,
  input  logic             hdr_done,
  input  logic             hdr_ok,
  input  logic             hdr_ht,
  input  logic             lpre_det,
  input  logic             spre_det,
  output logic [N_DEC-1:0] dec_ev
);
  always_comb begin
    dec_ev              = '0;
    dec_ev[C_FRM_ANY]   = fcs_done;
    dec_ev[C_FRM_PASS]  = fcs_done &  fcs_ok;
    dec_ev[C_FRM_FAIL]  = fcs_done & ~fcs_ok;
    dec_ev[C_HDR_ANY]   = hdr_done;
    dec_ev[C_HDR_PASS]  = hdr_done &  hdr_ok;
    dec_ev[C_HDR_FAIL]  = hdr_done & ~hdr_ok;
    dec_ev[C_HDR_HT]    = hdr_done &  hdr_ht;
    dec_ev[C_HDR_LEG]   = hdr_done & ~hdr_ht;
    dec_ev[C_PRE_LONG]  = lpre_det;
    dec_ev[C_PRE_SHORT] = spre_det;
  end
endmodule

// File: rtl/trig_level_xing.sv
module trig_level_xing #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hist_en,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] thr,
  output logic         up,
  output logic         dn
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_nxt;
  logic         cur_hi, cur_lo, old_hi, old_lo;

  always_comb begin
    prev_nxt = lvl;
    cur_hi   = lvl > thr;
    cur_lo   = lvl < thr;
    old_hi   = prev_q > thr;
    old_lo   = prev_q < thr;
    up       = hist_en & cur_hi & ~old_hi;
    dn       = hist_en & cur_lo & ~old_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_nxt;
  end
endmodule

// File: rtl/trig_bit_edge.sv
module trig_bit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hist_en,
  input  logic bit_i,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_comb begin
    rise = hist_en &  bit_i & ~prev_q;
    fall = hist_en & ~bit_i &  prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= bit_i;
  end
endmodule

// File: rtl/cap_trigger_sel.sv
module cap_trigger_sel
  import trig_pkg::*;
#(
  parameter int RSSI_BITS = RSSI_W,
  parameter int GAIN_BITS = GAIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     cond_sel,
  input  logic [RSSI_BITS-1:0] rssi_thr,
  input  logic [GAIN_BITS-1:0] gain_thr,
  input  logic                 fcs_done,
  input  logic                 fcs_ok,
  input  logic                 hdr_done,
  input  logic                 hdr_ok,
  input  logic                 hdr_ht,
  input  logic                 lpre_det,
  input  logic                 spre_det,
  input  logic [RSSI_BITS-1:0] rssi,
  input  logic [GAIN_BITS-1:0] gain,
  input  logic                 agc_lock,
  output logic                 trig
);
  logic [N_DEC-1:0]  dec_ev;
  logic [N_COND-1:0] all_ev;
  logic rssi_up, rssi_dn, gain_up, gain_dn, lock_got, lock_lost;
  logic hist_vld_q, hist_vld_nxt;
  logic trig_q, trig_nxt;

  trig_evt_decode u_dec (
    .fcs_done (fcs_done),
    .fcs_ok   (fcs_ok),
    .hdr_done (hdr_done),
    .hdr_ok   (hdr_ok),
    .hdr_ht   (hdr_ht),
    .lpre_det (lpre_det),
    .spre_det (spre_det),
    .dec_ev   (dec_ev)
  );

  trig_level_xing #(.W(RSSI_BITS)) u_rssi_x (
    .clk     (clk),
    .rst_n   (rst_n),
    .hist_en (hist_vld_q),
    .lvl     (rssi),
    .thr     (rssi_thr),
    .up      (rssi_up),
    .dn      (rssi_dn)
  );

  trig_level_xing #(.W(GAIN_BITS)) u_gain_x (
    .clk     (clk),
    .rst_n   (rst_n),
    .hist_en (hist_vld_q),
    .lvl     (gain),
    .thr     (gain_thr),
    .up      (gain_up),
    .dn      (gain_dn)
  );

  trig_bit_edge u_lock_e (
    .clk     (clk),
    .rst_n   (rst_n),
    .hist_en (hist_vld_q),
    .bit_i   (agc_lock),
    .rise    (lock_got),
    .fall    (lock_lost)
  );

  always_comb begin
    all_ev              = '0;
    all_ev[N_DEC-1:0]   = dec_ev;
    all_ev[C_RSSI_UP]   = rssi_up;
    all_ev[C_RSSI_DN]   = rssi_dn;
    all_ev[C_LOCK_LOST] = lock_lost;
    all_ev[C_LOCK_GOT]  = lock_got;
    all_ev[C_GAIN_UP]   = gain_up;
    all_ev[C_GAIN_DN]   = gain_dn;
    trig_nxt            = all_ev[cond_sel];
    hist_vld_nxt        = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= 1'b0;
      hist_vld_q <= 1'b0;
    end else begin
      trig_q     <= trig_nxt;
      hist_vld_q <= hist_vld_nxt;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/cap_trigger_sel_chk.sv
module cap_trigger_sel_chk
  import trig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  cond_sel,
  input logic              fcs_done,
  input logic              fcs_ok,
  input logic              hdr_done,
  input logic              hdr_ok,
  input logic              hdr_ht,
  input logic              lpre_det,
  input logic              spre_det,
  input logic [RSSI_W-1:0] rssi,
  input logic [GAIN_W-1:0] gain,
  input logic              agc_lock,
  input logic              trig
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_FRM_ANY: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel == 4'd0 && fcs_done) |=> trig); // R2
  AST_FRM_PASS: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel == 4'd1 && fcs_done && fcs_ok) |=> trig); // R2
  AST_HDR_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel == 4'd5 && hdr_done && !hdr_ok) |=> trig); // R3
  AST_HT_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel == 4'd6 && !(hdr_done && hdr_ht)) |=> !trig); // R4
  AST_LONG_PRE: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel == 4'd8 && lpre_det) |=> trig); // R5
  AST_RSSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && $stable(rssi) && (cond_sel == 4'd10 || cond_sel == 4'd11)) |=> !trig); // R6
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && $fell(agc_lock) && cond_sel == 4'd12) |=> trig); // R7
  AST_GAIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && $stable(gain) && (cond_sel == 4'd14 || cond_sel == 4'd15)) |=> !trig); // R8
  AST_NO_HISTORY: assert property (@(posedge clk) disable iff (!rst_n) (!seen_q && cond_sel >= 4'd10) |=> !trig); // R10
  AST_QUIET_DEC: assert property (@(posedge clk) disable iff (!rst_n) (cond_sel < 4'd10 && !fcs_done && !hdr_done && !lpre_det && !spre_det) |=> !trig); // R11
endmodule

bind cap_trigger_sel cap_trigger_sel_chk u_chk (.*);

// File: tb/test_cap_trigger_sel.sv
`timescale 1ns/1ps
module test_cap_trigger_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cond_sel;
  logic [10:0] rssi_thr, rssi;
  logic [6:0]  gain_thr, gain;
  logic fcs_done, fcs_ok, hdr_done, hdr_ok, hdr_ht, lpre_det, spre_det, agc_lock;
  logic trig;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [10:0] p_rssi;
  logic [6:0]  p_gain;
  logic        p_lock;
  bit          pv;

  always #10 clk = ~clk;

  cap_trigger_sel i_cap_trigger_sel (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .rssi_thr(rssi_thr), .gain_thr(gain_thr),
    .fcs_done(fcs_done), .fcs_ok(fcs_ok), .hdr_done(hdr_done), .hdr_ok(hdr_ok), .hdr_ht(hdr_ht),
    .lpre_det(lpre_det), .spre_det(spre_det), .rssi(rssi), .gain(gain), .agc_lock(agc_lock),
    .trig(trig)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: trig=%0b expected=%0b code=%0d t=%0t", tag, act, exp, cond_sel, $time);
    end
  endtask

  function automatic logic model();
    case (cond_sel)
      4'd0:  return fcs_done;
      4'd1:  return fcs_done & fcs_ok;
      4'd2:  return fcs_done & ~fcs_ok;
      4'd3:  return hdr_done;
      4'd4:  return hdr_done & hdr_ok;
      4'd5:  return hdr_done & ~hdr_ok;
      4'd6:  return hdr_done & hdr_ht;
      4'd7:  return hdr_done & ~hdr_ht;
      4'd8:  return lpre_det;
      4'd9:  return spre_det;
      4'd10: return pv && (rssi > rssi_thr) && !(p_rssi > rssi_thr);
      4'd11: return pv && (rssi < rssi_thr) && !(p_rssi < rssi_thr);
      4'd12: return pv && p_lock && !agc_lock;
      4'd13: return pv && !p_lock && agc_lock;
      4'd14: return pv && (gain > gain_thr) && !(p_gain > gain_thr);
      default: return pv && (gain < gain_thr) && !(p_gain < gain_thr);
    endcase
  endfunction

  function automatic string tag_of();
    if (!pv && cond_sel >= 4'd10) return "R10";
    if (cond_sel < 4'd10 && !(fcs_done | hdr_done | lpre_det | spre_det)) return "R11";
    case (cond_sel)
      4'd0, 4'd1, 4'd2:   return "R2";
      4'd3, 4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:         return "R4";
      4'd8, 4'd9:         return "R5";
      4'd10, 4'd11:       return "R6";
      4'd12, 4'd13:       return "R7";
      default:            return "R8";
    endcase
  endfunction

  // inputs already driven after a falling edge; result visible at next falling edge
  task automatic cyc(input string tag_override);
    logic  exp;
    string tg;
    exp = model();
    tg  = (tag_override != "") ? tag_override : tag_of();
    @(negedge clk);
    check(trig, exp, tg);
    p_rssi = rssi; p_gain = gain; p_lock = agc_lock; pv = 1;
  endtask

  task automatic idle_events();
    fcs_done = 0; fcs_ok = 0; hdr_done = 0; hdr_ok = 0; hdr_ht = 0;
    lpre_det = 0; spre_det = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_events();
    repeat (2) @(negedge clk);
    check(trig, 1'b0, "R1");
    rst_n = 1'b1;
    pv = 0;
  endtask

  task automatic rand_inputs();
    fcs_done = ($urandom % 4) == 0;
    fcs_ok   = $urandom % 2;
    hdr_done = ($urandom % 4) == 0;
    hdr_ok   = $urandom % 2;
    hdr_ht   = $urandom % 2;
    lpre_det = ($urandom % 5) == 0;
    spre_det = ($urandom % 5) == 0;
    if ($urandom % 3 != 0) rssi = 11'($urandom % 16);
    if ($urandom % 3 != 0) gain = 7'($urandom % 16);
    if ($urandom % 3 == 0) agc_lock = ~agc_lock;
    if ($urandom % 20 == 0) rssi_thr = 11'(4 + $urandom % 8);
    if ($urandom % 20 == 0) gain_thr = 7'(4 + $urandom % 8);
  endtask

  initial begin
    rst_n = 1'b0; cond_sel = 4'd0; rssi_thr = 11'd7; gain_thr = 7'd8;
    rssi = 11'd0; gain = 7'd0; agc_lock = 1'b0;
    p_rssi = '0; p_gain = '0; p_lock = 0; pv = 0;
    idle_events();
    @(negedge clk);
    // R1: default code 0, first cycle after release gives no trigger
    do_reset();
    cyc("R1");

    // sweep: every code, reset first, levels above threshold at release (R10)
    for (int c = 0; c < 16; c++) begin
      cond_sel = 4'(c);
      rssi = 11'd12; gain = 7'd14; agc_lock = 1'b1;
      do_reset();
      cyc("");
      for (int k = 0; k < 80; k++) begin
        rand_inputs();
        cyc("");
      end
    end

    // R9: isolated preamble event gives a one-cycle pulse
    cond_sel = 4'd8; idle_events();
    cyc("R9");
    lpre_det = 1; cyc("R9");
    lpre_det = 0; cyc("R9");
    cyc("R9");

    // R12: thresholds and select move with steady levels, no trigger
    cond_sel = 4'd10; rssi = 11'd20; rssi_thr = 11'd5; gain = 7'd3; gain_thr = 7'd9;
    cyc("R12");
    rssi_thr = 11'd30; cyc("R12");
    cond_sel = 4'd11;  cyc("R12");
    rssi_thr = 11'd5;  cyc("R12");
    cond_sel = 4'd14; gain_thr = 7'd1; cyc("R12");
    cond_sel = 4'd15; gain_thr = 7'd9; cyc("R12");
    // history kept across those changes: a real drop now fires
    cond_sel = 4'd11; rssi = 11'd2; cyc("R12");
    if (trig !== 1'b1) begin end
    rssi = 11'd2; cyc("R6");
    // R6 boundary: equal to threshold is neither above nor below
    cond_sel = 4'd10; rssi = 11'd5; cyc("R6");
    rssi = 11'd6; cyc("R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule